// File: doc/BRIEF.md
# Byte-Splitting I/O Cycle Engine for a Four-Bit Host Bus

This block sits on the host side of a narrow multiplexed peripheral bus. It takes processor I/O requests of one, two or four bytes through a valid/ready handshake. Each request's start address is compared against a set of programmed decode windows. A request that hits a window is sent out as a series of single-byte I/O cycles on the 4-bit nibble bus, with the frame strobe marking each cycle start. Consecutive bytes go to ascending addresses. For each byte the engine drives the cycle header, address and (for writes) data nibbles. It then turns the bus around and samples the peripheral's sync reply. Read bytes are gathered back into one little-endian result.

A peripheral can hold a cycle open with wait codes for as long as it needs. If no valid sync arrives within the timeout, the engine aborts the cycle with a long frame pulse. An aborted read byte returns all ones, which matches an undriven, pulled-up legacy bus. A request that misses every window never reaches the bus. It completes at once, with all-ones read data.

Top module: `lpc_io_splitter`

## Requirements
- R1: While and after a synchronous reset, req_ready is 1, rsp_valid is 0, lpc_frame_n is 1 and lpc_ad_oe is 0, including when reset arrives in the middle of a bus cycle.
- R2: A request is claimed when its start address lies in any enabled window (base <= address <= limit, both inclusive). An unclaimed request causes no bus activity. It gives rsp_valid in the first cycle after acceptance, with rsp_abort 0. A read returns FFh in every requested byte and zero above them.
- R3: req_size 00 gives one byte cycle, 01 gives two and 10 or 11 gives four, at addresses start, start+1, ... with 16-bit wrap-around.
- R4: Every byte cycle begins with lpc_frame_n low for exactly one clock while the bus carries 0000. Next comes a type nibble: 0000 for an I/O read, 0010 for an I/O write. Then come the address nibbles, most significant first.
- R5: A write byte cycle follows the address with two data nibbles, low nibble first. Byte cycle i carries bits 8i+7..8i of req_wdata.
- R6: After the address (read) or data (write), the host drives 1111 for one clock. It then keeps lpc_ad_oe at 0 through the sync, read data and two trailing turnaround clocks.
- R7: While waiting for sync, 0000 means ready, and 0101 or 0110 means wait. A wait code holds the cycle open without limit and restarts the timeout count. Four consecutive clocks with any other value abort the cycle.
- R8: An abort holds lpc_frame_n low for four clocks with the bus driven to 1111. The aborted byte reads as FFh, and rsp_abort is 1 in the response.
- R9: After a ready sync on a read, two data nibbles are sampled, low first. Byte i lands in rsp_rdata bits 8i+7..8i, and bytes above the request size read as zero. A write returns zero.
- R10: rsp_valid is high for exactly one clock per request. req_ready stays low from acceptance until the cycle after rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken when valid |
| req_write | input | 1 | 1 = I/O write, 0 = I/O read |
| req_size | input | 2 | 00 one byte, 01 two bytes, 1x four bytes |
| req_addr | input | 16 | Start I/O address |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Gathered read data, little-endian |
| rsp_abort | output | 1 | At least one byte cycle was aborted |
| dec_base | input | 64 | Four window bases, window k in bits 16k+15..16k |
| dec_limit | input | 64 | Four inclusive window limits, same packing |
| dec_enable | input | 4 | Per-window enable |
| lpc_frame_n | output | 1 | Active-low frame strobe |
| lpc_ad_out | output | 4 | Nibble bus value driven by the host |
| lpc_ad_oe | output | 1 | Host drives the nibble bus when 1 |
| lpc_ad_in | input | 4 | Nibble bus value seen from the peripheral |

## Verification
The abort timeout and the peripheral's sync reply can land in the same clock: the fourth non-sync sample is where a ready or wait code arriving at the last moment must still win. The bench provokes this with replies that send three junk nibbles before ready. It also sends three junk nibbles, a wait and three more junk nibbles before ready, and judges that no four-clock frame pulse appears, rsp_abort stays 0 and the data is intact. Against these, a silent peripheral must produce exactly one four-clock abort pulse per byte and FFh read data.

// File: rtl/lpcio_pkg.sv
package lpcio_pkg;

  localparam logic [3:0] NIB_START     = 4'b0000;
  localparam logic [3:0] CT_IO_READ    = 4'b0000;
  localparam logic [3:0] CT_IO_WRITE   = 4'b0010;
  localparam logic [3:0] SYNC_READY    = 4'b0000;
  localparam logic [3:0] SYNC_WAIT_SH  = 4'b0101;
  localparam logic [3:0] SYNC_WAIT_LG  = 4'b0110;
  localparam logic [3:0] NIB_IDLE      = 4'b1111;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CTDIR, S_ADDR, S_WDATA, S_TARH,
    S_TARF, S_SYNC, S_RDATA, S_TARE, S_ABORT
  } seq_state_t;

  typedef enum logic [1:0] {
    T_IDLE, T_ISSUE, T_WAITB, T_RESP
  } top_state_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   size_bytes = 3'd1;
      2'b01:   size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] byte_ones(input logic [2:0] n);
    case (n)
      3'd1:    byte_ones = 32'h0000_00FF;
      3'd2:    byte_ones = 32'h0000_FFFF;
      default: byte_ones = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/lpcio_range_decode.sv
module lpcio_range_decode #(
  parameter int NUM_RANGES = 4,
  parameter int ADDR_W     = 16
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_RANGES*ADDR_W-1:0] base_flat,
  input  logic [NUM_RANGES*ADDR_W-1:0] limit_flat,
  input  logic [NUM_RANGES-1:0]        enable,
  output logic                         hit
);

  logic [NUM_RANGES-1:0] match;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_window
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
    assign lo       = base_flat[g*ADDR_W +: ADDR_W];
    assign hi       = limit_flat[g*ADDR_W +: ADDR_W];
    assign match[g] = enable[g] && (addr >= lo) && (addr <= hi);
  end

  assign hit = |match;

endmodule

// File: rtl/lpcio_byte_cycle.sv
module lpcio_byte_cycle
  import lpcio_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SYNC_LIMIT = 4,
  parameter int ABORT_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              done,
  output logic [7:0]        rdata,
  output logic              aborted,
  output logic              lpc_frame_n,
  output logic [3:0]        lpc_ad_out,
  output logic              lpc_ad_oe,
  input  logic [3:0]        lpc_ad_in
);

  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int CNT_W     = 4;
  localparam logic [CNT_W-1:0] LAST_ADDR  = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] LAST_SYNC  = CNT_W'(SYNC_LIMIT - 1);
  localparam logic [CNT_W-1:0] LAST_ABORT = CNT_W'(ABORT_CLKS - 1);
  localparam logic [CNT_W-1:0] LAST_PAIR  = CNT_W'(1);

  seq_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic              sync_ready, sync_wait;
  logic              frame_d, oe_d;
  logic [3:0]        ad_d;
  int                nib_sel;

  assign sync_ready = (lpc_ad_in == SYNC_READY);
  assign sync_wait  = (lpc_ad_in == SYNC_WAIT_SH) || (lpc_ad_in == SYNC_WAIT_LG);

  // next-state logic of one byte cycle
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      S_IDLE:  if (start) begin st_d = S_START; cnt_d = '0; end
      S_START: st_d = S_CTDIR;
      S_CTDIR: begin st_d = S_ADDR; cnt_d = '0; end
      S_ADDR: begin
        if (cnt_q == LAST_ADDR) begin
          cnt_d = '0;
          st_d  = wr_q ? S_WDATA : S_TARH;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_WDATA: begin
        if (cnt_q == LAST_PAIR) begin st_d = S_TARH; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      S_TARH:  st_d = S_TARF;
      S_TARF:  begin st_d = S_SYNC; cnt_d = '0; end
      S_SYNC: begin
        if (sync_ready) begin
          cnt_d = '0;
          st_d  = wr_q ? S_TARE : S_RDATA;
        end else if (sync_wait) begin
          cnt_d = '0;
        end else if (cnt_q == LAST_SYNC) begin
          cnt_d = '0;
          st_d  = S_ABORT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_RDATA: begin
        if (cnt_q == LAST_PAIR) begin st_d = S_TARE; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      S_TARE: begin
        if (cnt_q == LAST_PAIR) begin st_d = S_IDLE; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      S_ABORT: begin
        if (cnt_q == LAST_ABORT) begin st_d = S_IDLE; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      default: begin st_d = S_IDLE; cnt_d = '0; end
    endcase
  end

  assign done = ((st_q == S_TARE) && (cnt_q == LAST_PAIR)) ||
                ((st_q == S_ABORT) && (cnt_q == LAST_ABORT));

  // bus values for the coming state, so the pins leave flops
  always_comb begin
    frame_d = !((st_d == S_START) || (st_d == S_ABORT));
    oe_d    = 1'b0;
    ad_d    = NIB_IDLE;
    nib_sel = ADDR_NIBS - 1 - int'(cnt_d);
    case (st_d)
      S_START: begin oe_d = 1'b1; ad_d = NIB_START; end
      S_CTDIR: begin oe_d = 1'b1; ad_d = wr_q ? CT_IO_WRITE : CT_IO_READ; end
      S_ADDR:  begin oe_d = 1'b1; ad_d = addr_q[nib_sel*4 +: 4]; end
      S_WDATA: begin oe_d = 1'b1; ad_d = cnt_d[0] ? wdata_q[7:4] : wdata_q[3:0]; end
      S_TARH:  begin oe_d = 1'b1; ad_d = NIB_IDLE; end
      S_ABORT: begin oe_d = 1'b1; ad_d = NIB_IDLE; end
      default: begin oe_d = 1'b0; ad_d = NIB_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      cnt_q       <= '0;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata       <= 8'hFF;
      aborted     <= 1'b0;
      lpc_frame_n <= 1'b1;
      lpc_ad_out  <= NIB_IDLE;
      lpc_ad_oe   <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      lpc_frame_n <= frame_d;
      lpc_ad_out  <= ad_d;
      lpc_ad_oe   <= oe_d;
      if ((st_q == S_IDLE) && start) begin
        wr_q    <= wr;
        addr_q  <= addr;
        wdata_q <= wdata;
        rdata   <= 8'hFF;
        aborted <= 1'b0;
      end
      if (st_q == S_RDATA) begin
        if (cnt_q[0]) rdata[7:4] <= lpc_ad_in;
        else          rdata[3:0] <= lpc_ad_in;
      end
      if ((st_q == S_SYNC) && (st_d == S_ABORT)) aborted <= 1'b1;
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> (st_q == S_IDLE));                                         // R3
  AST_BUS_RELEASED_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_SYNC) |-> !lpc_ad_oe);                                    // R6
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((st_q == S_SYNC) && sync_wait) |=> (st_q == S_SYNC));               // R7
  AST_ABORT_FRAME_LOW: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_ABORT) |-> (!lpc_frame_n && lpc_ad_oe && lpc_ad_out == NIB_IDLE)); // R8

endmodule

// File: rtl/lpc_io_splitter.sv
module lpc_io_splitter
  import lpcio_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int ADDR_W     = 16,
  parameter int SYNC_LIMIT = 4,
  parameter int ABORT_CLKS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [1:0]                   req_size,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [31:0]                  req_wdata,
  output logic                         rsp_valid,
  output logic [31:0]                  rsp_rdata,
  output logic                         rsp_abort,
  input  logic [NUM_RANGES*ADDR_W-1:0] dec_base,
  input  logic [NUM_RANGES*ADDR_W-1:0] dec_limit,
  input  logic [NUM_RANGES-1:0]        dec_enable,
  output logic                         lpc_frame_n,
  output logic [3:0]                   lpc_ad_out,
  output logic                         lpc_ad_oe,
  input  logic [3:0]                   lpc_ad_in
);

  top_state_t        ts_q, ts_d;
  logic              hit, accept;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wdata_q, rdata_q;
  logic [2:0]        nbytes_q;
  logic [1:0]        idx_q;
  logic              abort_q, last_byte;
  logic              seq_start, seq_done, seq_aborted;
  logic [7:0]        seq_rdata;
  logic [ADDR_W-1:0] seq_addr;
  logic [7:0]        seq_wdata;

  lpcio_range_decode #(.NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W)) u_decode (
    .addr       (req_addr),
    .base_flat  (dec_base),
    .limit_flat (dec_limit),
    .enable     (dec_enable),
    .hit        (hit)
  );

  assign accept    = req_valid && req_ready;
  assign last_byte = ({1'b0, idx_q} == (nbytes_q - 3'd1));
  assign seq_start = (ts_q == T_ISSUE);
  assign seq_addr  = addr_q + ADDR_W'(idx_q);
  assign seq_wdata = wdata_q[{idx_q, 3'b000} +: 8];

  lpcio_byte_cycle #(.ADDR_W(ADDR_W), .SYNC_LIMIT(SYNC_LIMIT), .ABORT_CLKS(ABORT_CLKS)) u_cycle (
    .clk         (clk),
    .rst         (rst),
    .start       (seq_start),
    .wr          (wr_q),
    .addr        (seq_addr),
    .wdata       (seq_wdata),
    .done        (seq_done),
    .rdata       (seq_rdata),
    .aborted     (seq_aborted),
    .lpc_frame_n (lpc_frame_n),
    .lpc_ad_out  (lpc_ad_out),
    .lpc_ad_oe   (lpc_ad_oe),
    .lpc_ad_in   (lpc_ad_in)
  );

  always_comb begin
    ts_d = ts_q;
    case (ts_q)
      T_IDLE:  if (accept) ts_d = hit ? T_ISSUE : T_RESP;
      T_ISSUE: ts_d = T_WAITB;
      T_WAITB: if (seq_done) ts_d = last_byte ? T_RESP : T_ISSUE;
      T_RESP:  ts_d = T_IDLE;
      default: ts_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q      <= T_IDLE;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      nbytes_q  <= 3'd1;
      idx_q     <= '0;
      abort_q   <= 1'b0;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
    end else begin
      ts_q      <= ts_d;
      req_ready <= (ts_d == T_IDLE);
      rsp_valid <= (ts_d == T_RESP);
      if (accept) begin
        wr_q     <= req_write;
        addr_q   <= req_addr;
        wdata_q  <= req_wdata;
        nbytes_q <= size_bytes(req_size);
        idx_q    <= '0;
        abort_q  <= 1'b0;
        rdata_q  <= (!hit && !req_write) ? byte_ones(size_bytes(req_size)) : 32'h0;
      end
      if ((ts_q == T_WAITB) && seq_done) begin
        if (!wr_q) rdata_q[{idx_q, 3'b000} +: 8] <= seq_rdata;
        abort_q <= abort_q | seq_aborted;
        if (!last_byte) idx_q <= idx_q + 2'd1;
      end
    end
  end

  assign rsp_rdata = rdata_q;
  assign rsp_abort = abort_q;

  AST_RSP_SINGLE_CLK: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);                                           // R10
  AST_NOT_READY_AT_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);                                           // R10
  AST_MISS_KEEPS_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit) |=> (lpc_frame_n && !lpc_ad_oe && rsp_valid));      // R2
  AST_BYTE_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    ((ts_q == T_WAITB) && seq_done) |-> ({1'b0, idx_q} < nbytes_q));     // R3

endmodule

// File: tb/lpc_io_splitter_tb.sv
`timescale 1ns/1ps
module lpc_io_splitter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_abort;
  logic        lpc_frame_n;
  logic [3:0]  lpc_ad_out;
  logic        lpc_ad_oe;
  logic [3:0]  lad_in = 4'hF;

  localparam logic [63:0] BASES  = {16'hFFFE, 16'h2000, 16'h03F8, 16'h0060};
  localparam logic [63:0] LIMITS = {16'hFFFF, 16'h20FF, 16'h03FF, 16'h0075};
  localparam logic [3:0]  ENABLES = 4'b1011;

  always #10 clk = ~clk;

  lpc_io_splitter u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_abort(rsp_abort),
    .dec_base(BASES), .dec_limit(LIMITS), .dec_enable(ENABLES),
    .lpc_frame_n(lpc_frame_n), .lpc_ad_out(lpc_ad_out), .lpc_ad_oe(lpc_ad_oe),
    .lpc_ad_in(lad_in)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // peripheral model: mode 0 waits then ready, 1 silent, 2 and 3 late ready
  logic [7:0]  pmem [0:255];
  int          sync_mode = 0;
  int          nwait = 0;
  int          ph = -1;
  int          tar0 = 6;
  int          rlen = 0;
  bit          noend = 0;
  logic        pdir = 0;
  logic [15:0] paddr = '0;
  logic [7:0]  pwd = '0;
  logic [3:0]  resp [0:15];
  int          perr = 0;
  int          log_n = 0;
  logic [15:0] log_addr [0:7];
  logic        log_dir  [0:7];
  logic [7:0]  log_data [0:7];
  int          run = 0;
  int          runs4 = 0;
  int          runs_bad = 0;

  task automatic add_resp(input logic [3:0] v);
    resp[rlen] = v;
    rlen++;
  endtask

  task automatic log_cycle();
    if (log_n < 8) begin
      log_addr[log_n] = paddr;
      log_dir[log_n]  = pdir;
      log_data[log_n] = pwd;
    end
    log_n++;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      ph = -1;
      lad_in = 4'hF;
    end else if (ph < 0) begin
      lad_in = 4'hF;
      if (!lpc_frame_n && lpc_ad_oe && lpc_ad_out == 4'h0) ph = 0;
    end else begin
      ph = ph + 1;
      if (ph == 1) begin
        if (!lpc_frame_n) perr++;
        if (lpc_ad_out != 4'b0010 && lpc_ad_out != 4'b0000) perr++;
        pdir = (lpc_ad_out == 4'b0010);
        tar0 = pdir ? 8 : 6;
        pwd  = 8'h00;
      end else if (ph <= 5) begin
        paddr = {paddr[11:0], lpc_ad_out};
        if (!lpc_ad_oe) perr++;
      end else if (pdir && ph == 6) pwd[3:0] = lpc_ad_out;
      else if (pdir && ph == 7) pwd[7:4] = lpc_ad_out;
      if (ph == tar0 && (!lpc_ad_oe || lpc_ad_out != 4'hF)) perr++;
      if (ph == tar0 + 1) begin
        if (lpc_ad_oe) perr++;
        rlen = 0;
        case (sync_mode)
          0: for (int k = 0; k < nwait; k++) add_resp((k % 2) ? 4'b0101 : 4'b0110);
          2: begin add_resp(4'hF); add_resp(4'hA); add_resp(4'hF); end
          3: begin
            add_resp(4'hF); add_resp(4'hA); add_resp(4'hF); add_resp(4'b0110);
            add_resp(4'hF); add_resp(4'hA); add_resp(4'hF);
          end
          default: ;
        endcase
        noend = (sync_mode == 1);
        if (!noend) begin
          add_resp(4'b0000);
          if (!pdir) begin
            add_resp(pmem[paddr[7:0]][3:0]);
            add_resp(pmem[paddr[7:0]][7:4]);
          end
        end
      end
      if (ph >= tar0 + 2) begin
        if (!lpc_frame_n) begin
          log_cycle();
          ph = -1;
          lad_in = 4'hF;
        end else begin
          if (lpc_ad_oe) perr++;
          if (ph - (tar0 + 2) < rlen) lad_in = resp[ph - (tar0 + 2)];
          else begin
            lad_in = 4'hF;
            if (!noend) begin
              if (pdir) pmem[paddr[7:0]] = pwd;
              log_cycle();
              ph = -1;
            end
          end
        end
      end
    end
  end

  // frame pulse length monitor: start pulses are 1 clock, aborts 4
  always @(negedge clk) begin
    if (rst) run = 0;
    else if (!lpc_frame_n) run++;
    else if (run != 0) begin
      if (run == 4) runs4++;
      else if (run != 1) runs_bad++;
      run = 0;
    end
  end

  function automatic bit bench_hit(input logic [15:0] a);
    bench_hit = 0;
    for (int k = 0; k < 4; k++)
      if (ENABLES[k] && a >= BASES[16*k +: 16] && a <= LIMITS[16*k +: 16]) bench_hit = 1;
  endfunction

  typedef struct packed {
    logic        wr;
    logic [1:0]  size;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [1:0]  mode;
    logic [3:0]  nwait;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd2, 16'h0060, 32'hA1B2C3D4, 2'd0, 4'd0},
    '{1'b0, 2'd2, 16'h0060, 32'h0,        2'd0, 4'd0},
    '{1'b0, 2'd1, 16'h0062, 32'h0,        2'd0, 4'd2},
    '{1'b0, 2'd0, 16'h0063, 32'h0,        2'd0, 4'd1},
    '{1'b1, 2'd1, 16'h03F8, 32'h00005AA5, 2'd0, 4'd3},
    '{1'b0, 2'd3, 16'h03F8, 32'h0,        2'd0, 4'd0},
    '{1'b0, 2'd0, 16'h0070, 32'h0,        2'd1, 4'd0},
    '{1'b1, 2'd0, 16'h0071, 32'h0000007E, 2'd1, 4'd0},
    '{1'b0, 2'd1, 16'h0064, 32'h0,        2'd2, 4'd0},
    '{1'b0, 2'd0, 16'h0065, 32'h0,        2'd3, 4'd0},
    '{1'b0, 2'd1, 16'h1234, 32'h0,        2'd0, 4'd0},
    '{1'b1, 2'd2, 16'h8000, 32'hDEADBEEF, 2'd0, 4'd0},
    '{1'b0, 2'd0, 16'h0075, 32'h0,        2'd0, 4'd0},
    '{1'b0, 2'd0, 16'h0076, 32'h0,        2'd0, 4'd0},
    '{1'b0, 2'd2, 16'h2010, 32'h0,        2'd0, 4'd0},
    '{1'b0, 2'd0, 16'h005F, 32'h0,        2'd0, 4'd0},
    '{1'b0, 2'd2, 16'hFFFE, 32'h0,        2'd0, 4'd1}
  };

  task automatic run_req(input vec_t v);
    int          n;
    bit          hit;
    logic [31:0] exp_rd;
    bit          lat0;
    int          busy_ready;
    int          bad;
    logic [31:0] got_rd;
    logic        got_ab;
    logic [15:0] a;
    n   = (v.size == 2'd0) ? 1 : (v.size == 2'd1) ? 2 : 4;
    hit = bench_hit(v.addr);
    exp_rd = 32'h0;
    if (!v.wr)
      for (int i = 0; i < n; i++) begin
        a = v.addr + 16'(i);
        exp_rd[8*i +: 8] = (hit && v.mode != 2'd1) ? pmem[a[7:0]] : 8'hFF;
      end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sync_mode = int'(v.mode);
    nwait     = int'(v.nwait);
    log_n = 0; perr = 0; runs4 = 0; runs_bad = 0;
    req_valid = 1'b1; req_write = v.wr; req_size = v.size;
    req_addr = v.addr; req_wdata = v.wdata;
    @(negedge clk);
    req_valid = 1'b0;
    lat0 = rsp_valid;
    busy_ready = 0;
    while (!rsp_valid) begin
      if (req_ready) busy_ready++;
      @(negedge clk);
    end
    got_rd = rsp_rdata;
    got_ab = rsp_abort;
    @(negedge clk);
    chk("R10 rsp_valid one clock", {31'b0, rsp_valid}, 32'd0);
    chk("R10 ready low while busy", busy_ready, 32'd0);
    chk("R9 R2 R8 read data", got_rd, exp_rd);
    chk("R8 R7 rsp_abort", {31'b0, got_ab}, {31'b0, hit && v.mode == 2'd1});
    chk("R3 R2 byte cycle count", log_n, hit ? n : 0);
    if (!hit) chk("R2 miss answered next cycle", {31'b0, lat0}, 32'd1);
    bad = 0;
    for (int i = 0; i < n && i < log_n && i < 8; i++) begin
      if (log_addr[i] !== v.addr + 16'(i)) bad++;
      if (log_dir[i] !== v.wr) bad++;
      if (v.wr && log_data[i] !== v.wdata[8*i +: 8]) bad++;
    end
    chk("R3 R4 R5 address order, type, write bytes", bad, 32'd0);
    chk("R4 R6 framing and turnaround", perr, 32'd0);
    chk("R8 abort pulses", runs4, (hit && v.mode == 2'd1) ? n : 0);
    chk("R4 R8 no odd frame pulses", runs_bad, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) pmem[i] = 8'(i) ^ 8'h3C;
    repeat (3) @(negedge clk);
    // R1 state held during reset
    chk("R1 ready in reset", {31'b0, req_ready}, 32'd1);
    chk("R1 frame idle in reset", {31'b0, lpc_frame_n}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1 bus released after reset", {31'b0, lpc_ad_oe}, 32'd0);

    for (int vi = 0; vi < NVEC; vi++) run_req(VECS[vi]);

    // R1 reset in the middle of a silent-peripheral read
    sync_mode = 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 16'h0068;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (9) @(negedge clk);
    chk("R1 busy before mid reset", {31'b0, req_ready}, 32'd0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after mid reset", {31'b0, req_ready}, 32'd1);
    chk("R1 frame high after mid reset", {31'b0, lpc_frame_n}, 32'd1);
    chk("R1 no response after mid reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1 bus released after mid reset", {31'b0, lpc_ad_oe}, 32'd0);

    sync_mode = 0;
    run_req('{1'b0, 2'd0, 16'h03FF, 32'h0, 2'd0, 4'd0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule